// File: doc/BRIEF.md
# Duplicate-Tolerant Port-to-Module Routing Crossbar

This block steers byte-wide packet streams from a small set of input ports onto a larger set of memory-module lanes. Each input port presents a destination index `i` together with two packet tags (`j`, `k`). When the port pulses its load strobe, the index is decoded and held for the rest of the packet. From then on the port's data bytes flow combinationally to the selected lane, and the lane carries the tags with them.

A lane normally receives at most one packet per switch cycle. Two ports may still pick the same lane. In that case the lane raises a duplicate flag, and the module behind it drives a per-lane toggle. With the toggle low, the lane forwards the lowest-numbered competing port. With the toggle high, it forwards the highest-numbered competing port. A module that flips the toggle every byte cycle therefore interleaves the two packets. Index values are one-based: 0 and anything above the lane count select no lane.

Top module: `dup_xbar`

## Requirements
- R1: A load with `i` in 1..NUM_OUT (4-bit field per port) routes that port to lane `i`-1. A load with `i` = 0 or `i` > NUM_OUT routes that port to no lane.
- R2: A port's routing and tags change only in a cycle where its `in_load` bit is high. Changes on `in_i`, `in_j` or `in_k` without a load have no effect on any lane.
- R3: `out_present[n]` is high exactly when at least one port routes to lane n. When it is low, that lane's data, j and k are all zero.
- R4: `out_dup[n]` is high exactly when two or more ports route to lane n.
- R5: With `toggle[n]` low, lane n forwards the lowest-numbered port that routes to it.
- R6: With `toggle[n]` high, lane n forwards the highest-numbered port that routes to it. A lane with a single source forwards that port for either toggle value.
- R7: `out_j` and `out_k` of a lane carry the j and k that the forwarded port captured at its last load.
- R8: Lane data follows the forwarded port's `in_data` in the same cycle, with no register in between.
- R9: While reset is low, and at the first edge after it, no port routes anywhere: every lane shows present=0, dup=0 and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_load | input | NUM_IN | Per-port strobe that captures i, j and k |
| in_i | input | NUM_IN*IW | Per-port one-based destination lane index |
| in_j | input | NUM_IN*JW | Per-port j tag |
| in_k | input | NUM_IN*KW | Per-port k tag |
| in_data | input | NUM_IN*DW | Per-port data byte |
| toggle | input | NUM_OUT | Per-lane selection between lowest and highest competing port |
| out_data | output | NUM_OUT*DW | Per-lane data byte |
| out_j | output | NUM_OUT*JW | Per-lane j tag |
| out_k | output | NUM_OUT*KW | Per-lane k tag |
| out_present | output | NUM_OUT | Lane has at least one source |
| out_dup | output | NUM_OUT | Lane has two or more sources |

## Verification
The bench puts two and then three ports on one lane and flips the toggle. A design that searched both encoders the same way would forward the same port for either toggle value. A design that counted sources wrongly would miss the flag or raise it for single-source lanes. The out-of-range indices 0 and 9 are loaded; an off-by-one decode would light lane 0 or wrap onto a real lane. Indices and tags are also changed without a load; a design that decoded the live index would reroute traffic in mid-packet. A reset in the middle of the run checks that every stale route is dropped.

// File: rtl/dup_xbar.sv
module dup_xbar #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 8,
  parameter int DW      = 8,
  parameter int JW      = 4,
  parameter int KW      = 2,
  parameter int IW      = $clog2(NUM_OUT + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_IN-1:0]       in_load,
  input  logic [NUM_IN*IW-1:0]    in_i,
  input  logic [NUM_IN*JW-1:0]    in_j,
  input  logic [NUM_IN*KW-1:0]    in_k,
  input  logic [NUM_IN*DW-1:0]    in_data,
  input  logic [NUM_OUT-1:0]      toggle,
  output logic [NUM_OUT*DW-1:0]   out_data,
  output logic [NUM_OUT*JW-1:0]   out_j,
  output logic [NUM_OUT*KW-1:0]   out_k,
  output logic [NUM_OUT-1:0]      out_present,
  output logic [NUM_OUT-1:0]      out_dup
);
  localparam int PW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [NUM_OUT-1:0] port_hot [NUM_IN];
  logic [JW-1:0]      port_j   [NUM_IN];
  logic [KW-1:0]      port_k   [NUM_IN];

  function automatic logic [NUM_OUT-1:0] decode_idx(input logic [IW-1:0] idx);
    logic [NUM_OUT-1:0] v;
    v = '0;
    for (int n = 0; n < NUM_OUT; n++)
      if (int'(idx) == n + 1) v[n] = 1'b1;
    return v;
  endfunction

  function automatic logic [PW-1:0] first_set(input logic [NUM_IN-1:0] vec);
    logic [PW-1:0] r;
    r = '0;
    for (int p = NUM_IN - 1; p >= 0; p--)
      if (vec[p]) r = PW'(p);
    return r;
  endfunction

  for (genvar p = 0; p < NUM_IN; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        port_hot[p] <= '0;
        port_j[p]   <= '0;
        port_k[p]   <= '0;
      end else if (in_load[p]) begin
        port_hot[p] <= decode_idx(in_i[p*IW +: IW]);
        port_j[p]   <= in_j[p*JW +: JW];
        port_k[p]   <= in_k[p*KW +: KW];
      end
    end
  end

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    logic [NUM_IN-1:0] sel, sel_rev;
    logic [PW-1:0]     pick_lo, pick_hi_rev, pick_hi, pick;

    for (genvar p = 0; p < NUM_IN; p++) begin : g_sel
      assign sel[p]                = port_hot[p][n];
      assign sel_rev[NUM_IN-1-p]   = port_hot[p][n];
    end

    assign pick_lo     = first_set(sel);
    assign pick_hi_rev = first_set(sel_rev);
    assign pick_hi     = PW'(NUM_IN - 1) - pick_hi_rev;
    assign pick        = toggle[n] ? pick_hi : pick_lo;

    assign out_present[n] = |sel;
    assign out_dup[n]     = $countones(sel) > 1;

    assign out_data[n*DW +: DW] = out_present[n] ? in_data[int'(pick)*DW +: DW] : '0;
    assign out_j[n*JW +: JW]    = out_present[n] ? port_j[pick] : '0;
    assign out_k[n*KW +: KW]    = out_present[n] ? port_k[pick] : '0;
  end
endmodule

// File: rtl/dup_xbar_chk.sv
module dup_xbar_chk #(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 8,
  parameter int DW      = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_IN-1:0]     in_load,
  input logic [NUM_OUT*DW-1:0] out_data,
  input logic [NUM_OUT-1:0]    out_present,
  input logic [NUM_OUT-1:0]    out_dup
);
  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !out_present[n] |-> out_data[n*DW +: DW] == '0); // R3
    AST_DUP_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_dup[n] |-> out_present[n]); // R4
  end

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_load == '0 |=> $stable(out_present) && $stable(out_dup)); // R2

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> out_present == '0 && out_dup == '0); // R9

  AST_DUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_dup) <= NUM_IN / 2); // R4
endmodule

bind dup_xbar dup_xbar_chk #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_load(in_load),
  .out_data(out_data), .out_present(out_present), .out_dup(out_dup)
);

// File: tb/dup_xbar_bench.sv
module dup_xbar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4, NO = 8, DW = 8, JW = 4, KW = 2, IW = 4;

  logic clk = 0, rst_n = 0;
  logic [NI-1:0]    in_load = '0;
  logic [NI*IW-1:0] in_i = '0;
  logic [NI*JW-1:0] in_j = '0;
  logic [NI*KW-1:0] in_k = '0;
  logic [NI*DW-1:0] in_data = '0;
  logic [NO-1:0]    toggle = '0;
  logic [NO*DW-1:0] out_data;
  logic [NO*JW-1:0] out_j;
  logic [NO*KW-1:0] out_k;
  logic [NO-1:0]    out_present, out_dup;

  dup_xbar u_dup_xbar (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_i [NI];
  int m_j [NI];
  int m_k [NI];
  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NI; p++) begin m_i[p] <= 0; m_j[p] <= 0; m_k[p] <= 0; end
    end else begin
      for (int p = 0; p < NI; p++)
        if (in_load[p]) begin
          m_i[p] <= int'(in_i[p*IW +: IW]);
          m_j[p] <= int'(in_j[p*JW +: JW]);
          m_k[p] <= int'(in_k[p*KW +: KW]);
        end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compares every lane against the reference model
  task automatic compare();
    for (int n = 0; n < NO; n++) begin
      int cnt = 0, lo = -1, hi = -1, ch;
      int ed, ej, ek;
      for (int p = 0; p < NI; p++)
        if (m_i[p] >= 1 && m_i[p] <= NO && m_i[p] - 1 == n) begin
          cnt++;
          if (lo < 0) lo = p;
          hi = p;
        end
      ch = toggle[n] ? hi : lo;
      ed = cnt > 0 ? int'(in_data[ch*DW +: DW]) : 0;
      ej = cnt > 0 ? m_j[ch] : 0;
      ek = cnt > 0 ? m_k[ch] : 0;
      chk($sformatf("R1/R3 present lane %0d", n), int'(out_present[n]), cnt > 0 ? 1 : 0);
      chk($sformatf("R4 dup lane %0d", n), int'(out_dup[n]), cnt > 1 ? 1 : 0);
      chk($sformatf("R5/R6/R8 data lane %0d", n), int'(out_data[n*DW +: DW]), ed);
      chk($sformatf("R7 j lane %0d", n), int'(out_j[n*JW +: JW]), ej);
      chk($sformatf("R7 k lane %0d", n), int'(out_k[n*KW +: KW]), ek);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    compare();
    in_load = '0;
    in_data = $urandom;
  endtask

  task automatic load(input int p, input int iv, input int jv, input int kv);
    in_load[p] = 1'b1;
    in_i[p*IW +: IW] = IW'(iv);
    in_j[p*JW +: JW] = JW'(jv);
    in_k[p*KW +: KW] = KW'(kv);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    #3; compare();
    repeat (2) cyc();
    rst_n = 1;
    cyc(); cyc();
    // R1 distinct lanes
    load(0, 1, 3, 1); load(1, 4, 5, 2); load(2, 8, 7, 3); load(3, 6, 9, 0);
    repeat (4) cyc();
    // R8 data follows, R6 single source toggle-invariant
    toggle = 8'hFF; repeat (3) cyc(); toggle = '0;
    // R2 live changes without load
    in_i = 16'h1111; in_j = 16'hABCD; in_k = 8'hFF; repeat (3) cyc();
    // R4/R5/R6 two-way conflict with alternating toggle
    load(1, 3, 2, 1); load(3, 3, 14, 3); cyc();
    for (int t = 0; t < 6; t++) begin toggle[2] = ~toggle[2]; cyc(); end
    // three-way conflict
    load(0, 3, 1, 2); cyc();
    for (int t = 0; t < 4; t++) begin toggle[2] = ~toggle[2]; cyc(); end
    // R1 out-of-range indices
    load(0, 0, 5, 1); load(1, 9, 6, 2); load(3, 15, 7, 3); repeat (3) cyc();
    // random sweep
    for (int t = 0; t < 200; t++) begin
      for (int p = 0; p < NI; p++)
        if ($urandom_range(3) == 0) load(p, $urandom_range(10), $urandom_range(15), $urandom_range(3));
      toggle = $urandom;
      cyc();
    end
    // R9 reset mid-run
    load(0, 2, 1, 1); load(2, 2, 2, 2); cyc();
    rst_n = 0; #1; compare();
    cyc(); rst_n = 1; cyc(); cyc();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule